// File: doc/BRIEF.md
# In-Order Retirement Queue with Interrupt Gating

This block tracks instructions from dispatch to retirement in a small circular queue and retires them strictly in program order, even when execution units report finishes out of order. A dispatch allocates the slot at the tail and returns its slot number as a tag. An execution unit later reports a finish against that tag, optionally flagging an exception. Register results may be committed only on the retire strobes. Stores never go to memory early. A store that retires is parked in a single completed-store slot, which then asks the memory port for service.

An asynchronous interrupt request is gated by the enable bit of a small machine-state register. When it is pending, the block lets at most the oldest entry resolve. That entry either retires or raises its own exception, and the exception wins. Every younger entry is held back. The block then waits until the completed-store slot has started its memory access, signals the interrupt as taken, and discards the held entries. On any take, the resume address and the machine state are captured into two save registers.

Top module: `retire_queue`

## Requirements
- R1: Entries retire oldest first and only after they have finished without an exception; a finish to a younger entry retires nothing while an older one is unfinished. Up to two entries retire per cycle. `ret_valid[0]` marks the oldest retiring entry, and `ret_valid[1]` is set only together with it.
- R2: `disp_ready` is low while all 5 slots are occupied, while an interrupt is pending, or while an exception is being taken. Slots are handed out as tags 0,1,2,3,4 and then wrap back to 0.
- R3: A store enters the completed-store slot in the cycle it retires. `mem_req` rises in the following cycle, and `mem_pc` carries the store's address. `mem_req` is never raised for a store that has not retired.
- R4: The completed-store slot empties at the clock edge where `mem_req` and `mem_gnt` are both high. A retiring store that finds the slot occupied, with no grant in the same cycle, stalls; every younger entry stalls with it. While `mem_req` is high without a grant, `mem_pc` is held.
- R5: An interrupt is pending while `irq_req` is high and bit 0 of the machine state (the enable bit) is 1. While it is pending, no more than the head entry retires in any cycle, and once one entry has retired, no further entry retires.
- R6: When the head entry has finished with its exception flag set (and no entry has already retired under a pending interrupt), `trap_take` is raised in that cycle, even if an interrupt is pending. `irq_take` stays low in that cycle.
- R7: `irq_take` is raised when an interrupt is pending, the completed-store slot is empty, and either the queue is empty or an entry has retired while the request was pending. `save_pc` then receives the address of the oldest remaining entry, or `fetch_pc` if the queue is empty.
- R8: On a take (either kind), `save_msr` receives the machine state as it was before the take, the enable bit is cleared, and every queue entry is discarded. The next dispatch gets tag 0, and a late finish to a discarded tag retires nothing.
- R9: With the enable bit at 0, `irq_req` has no effect: dual retirement and dispatch continue as normal.
- R10: `msr_wr` loads `msr_wdata` into the machine state. A take in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | Address of the dispatched instruction |
| disp_store | input | 1 | Dispatched instruction is a store |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | PTR_W | Slot allocated to the dispatch |
| fin_valid | input | 1 | Finish report from an execution unit |
| fin_tag | input | PTR_W | Slot that finished |
| fin_exc | input | 1 | The finished instruction raised an exception |
| ret_valid | output | 2 | Retire strobes, bit 0 oldest |
| mem_req | output | 1 | Completed store waiting for the memory port |
| mem_pc | output | PC_W | Address of the waiting store |
| mem_gnt | input | 1 | Memory port starts the access |
| irq_req | input | 1 | Level-sensitive interrupt request |
| fetch_pc | input | PC_W | Next address to dispatch when the queue is empty |
| msr_wr | input | 1 | Machine-state write strobe |
| msr_wdata | input | MSR_W | Machine-state write value |
| msr | output | MSR_W | Current machine state, bit 0 enable |
| trap_take | output | 1 | Head exception taken this cycle |
| irq_take | output | 1 | Interrupt taken this cycle |
| save_pc | output | PC_W | Saved resume address |
| save_msr | output | MSR_W | Saved machine state |

## Verification
Most internal faults here show up at the ports within one or two cycles. If a head or tail pointer slips, `disp_tag` comes out of order or a retire strobe fires against an unfinished slot. A stuck drained-flag in the store slot shows as `irq_take` firing while `mem_req` is still high, or never firing at all. Bad gating under a pending interrupt shows as a second retire strobe in the window. A flush that leaves stale slots behind shows the next time a late finish is reported, as a retire strobe with nothing dispatched.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
    logic store;
  } cq_flags_t;

  // Advance a ring index by step, wrapping at depth.
  function automatic int f_ring_next(input int ptr, input int step, input int depth);
    return (ptr + step) % depth;
  endfunction

  // New occupancy after allocations and retirements.
  function automatic int f_occ_next(input int occ, input int add, input int sub);
    return occ + add - sub;
  endfunction

  // Resume address: oldest remaining entry, or the fetch address when empty.
  function automatic logic [63:0] f_resume(input logic empty, input logic [63:0] head_pc,
                                           input logic [63:0] fetch);
    return empty ? fetch : head_pc;
  endfunction

endpackage

// File: rtl/cq_ring.sv
module cq_ring
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int PC_W  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [PC_W-1:0]  alloc_pc,
  input  logic             alloc_store,
  input  logic             fin_valid,
  input  logic [PTR_W-1:0] fin_tag,
  input  logic             fin_exc,
  input  logic [1:0]       pop_cnt,
  input  logic             flush,
  output logic [PTR_W-1:0] tail_ptr,
  output logic [OCC_W-1:0] occ,
  output cq_flags_t        h0_f,
  output logic [PC_W-1:0]  h0_pc,
  output cq_flags_t        h1_f,
  output logic [PC_W-1:0]  h1_pc
);

  logic [PTR_W-1:0] head_q, tail_q, head1;
  logic [OCC_W-1:0] occ_q;
  cq_flags_t [DEPTH-1:0] f_all;
  logic [DEPTH-1:0][PC_W-1:0] pc_all;

  assign head1 = PTR_W'(f_ring_next(int'(head_q), 1, DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    cq_flags_t       f_q;
    logic [PC_W-1:0] pc_q;
    logic            hit_alloc, hit_pop, hit_fin;

    assign hit_alloc = alloc && (tail_q == PTR_W'(g));
    assign hit_pop   = ((pop_cnt != 2'd0) && (head_q == PTR_W'(g))) ||
                       ((pop_cnt == 2'd2) && (head1 == PTR_W'(g)));
    assign hit_fin   = fin_valid && (fin_tag == PTR_W'(g)) && f_q.valid;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        f_q <= '0;
      end else if (hit_alloc) begin
        f_q <= '{valid: 1'b1, done: 1'b0, exc: 1'b0, store: alloc_store};
      end else if (hit_pop) begin
        f_q <= '0;
      end else if (hit_fin) begin
        f_q.done <= 1'b1;
        f_q.exc  <= fin_exc;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) pc_q <= alloc_pc;
    end

    assign f_all[g]  = f_q;
    assign pc_all[g] = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= PTR_W'(f_ring_next(int'(head_q), int'(pop_cnt), DEPTH));
      if (alloc) tail_q <= PTR_W'(f_ring_next(int'(tail_q), 1, DEPTH));
      occ_q  <= OCC_W'(f_occ_next(int'(occ_q), int'(alloc), int'(pop_cnt)));
    end
  end

  assign tail_ptr = tail_q;
  assign occ      = occ_q;
  assign h0_f     = f_all[head_q];
  assign h0_pc    = pc_all[head_q];
  assign h1_f     = f_all[head1];
  assign h1_pc    = pc_all[head1];

endmodule

// File: rtl/cq_retire.sv
module cq_retire
  import cq_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  cq_flags_t       h0_f,
  input  logic [PC_W-1:0] h0_pc,
  input  cq_flags_t       h1_f,
  input  logic [PC_W-1:0] h1_pc,
  input  logic            pend,
  input  logic            gate_done,
  input  logic            sb_full,
  input  logic            mem_gnt,
  output logic [1:0]      ret_valid,
  output logic [1:0]      pop_cnt,
  output logic            push,
  output logic [PC_W-1:0] push_pc
);

  logic room, ok0, ok1, r0, r1;

  assign room = !sb_full || mem_gnt;
  assign ok0  = h0_f.valid && h0_f.done && !h0_f.exc;
  assign ok1  = h1_f.valid && h1_f.done && !h1_f.exc;

  // Head may go unless the gate has already used its one retirement.
  assign r0 = ok0 && !gate_done && (!h0_f.store || room);
  // Second slot only with no interrupt pending and store-slot room left.
  assign r1 = r0 && !pend && ok1 && (!h1_f.store || (room && !h0_f.store));

  assign ret_valid = {r1, r0};
  assign pop_cnt   = 2'(r0) + 2'(r1);
  assign push      = (r0 && h0_f.store) || (r1 && h1_f.store);
  assign push_pc   = (r0 && h0_f.store) ? h0_pc : h1_pc;

endmodule

// File: rtl/cq_stbuf.sv
module cq_stbuf #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_pc,
  input  logic            mem_gnt,
  output logic            full,
  output logic [PC_W-1:0] mem_pc
);

  logic            full_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      if (push) pc_q <= push_pc;
      full_q <= push || (full_q && !mem_gnt);
    end
  end

  assign full   = full_q;
  assign mem_pc = pc_q;

endmodule

// File: rtl/cq_irq_gate.sv
module cq_irq_gate
  import cq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic             msr_wr,
  input  logic [MSR_W-1:0] msr_wdata,
  input  cq_flags_t        h0_f,
  input  logic [PC_W-1:0]  h0_pc,
  input  logic             q_empty,
  input  logic             sb_full,
  input  logic             head_ret,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             pend,
  output logic             gate_done,
  output logic             trap_take,
  output logic             irq_take,
  output logic [MSR_W-1:0] msr,
  output logic [PC_W-1:0]  save_pc,
  output logic [MSR_W-1:0] save_msr
);

  logic             gate_q, take;
  logic [MSR_W-1:0] msr_q, ssr_q;
  logic [PC_W-1:0]  spc_q;
  logic [63:0]      resume;

  assign pend      = irq_req && msr_q[0];
  assign trap_take = h0_f.valid && h0_f.done && h0_f.exc && !gate_q;
  assign irq_take  = pend && !trap_take && !sb_full && (gate_q || q_empty);
  assign take      = trap_take || irq_take;
  assign resume    = f_resume(q_empty, 64'(h0_pc), 64'(fetch_pc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      msr_q  <= '0;
      ssr_q  <= '0;
      spc_q  <= '0;
    end else begin
      gate_q <= pend && !take && (gate_q || head_ret);
      if (take) begin
        msr_q <= msr_q & ~MSR_W'(1);
        ssr_q <= msr_q;
        spc_q <= resume[PC_W-1:0];
      end else if (msr_wr) begin
        msr_q <= msr_wdata;
      end
    end
  end

  assign gate_done = gate_q;
  assign msr       = msr_q;
  assign save_pc   = spc_q;
  assign save_msr  = ssr_q;

endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int PC_W  = 16,
  parameter int MSR_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [PC_W-1:0]  disp_pc,
  input  logic             disp_store,
  output logic             disp_ready,
  output logic [PTR_W-1:0] disp_tag,
  input  logic             fin_valid,
  input  logic [PTR_W-1:0] fin_tag,
  input  logic             fin_exc,
  output logic [1:0]       ret_valid,
  output logic             mem_req,
  output logic [PC_W-1:0]  mem_pc,
  input  logic             mem_gnt,
  input  logic             irq_req,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             msr_wr,
  input  logic [MSR_W-1:0] msr_wdata,
  output logic [MSR_W-1:0] msr,
  output logic             trap_take,
  output logic             irq_take,
  output logic [PC_W-1:0]  save_pc,
  output logic [MSR_W-1:0] save_msr
);

  // Named internal events, visible to the bound checker.
  logic [OCC_W-1:0] occ_w;
  logic             pend_w, gate_w, sb_full_w, push_w, flush_w, alloc_w;
  logic [1:0]       pop_w;
  logic [PC_W-1:0]  push_pc_w, h0_pc_w, h1_pc_w;
  cq_flags_t        h0_w, h1_w;

  assign flush_w    = trap_take || irq_take;
  assign disp_ready = (occ_w != OCC_W'(DEPTH)) && !pend_w && !trap_take;
  assign alloc_w    = disp_valid && disp_ready;
  assign mem_req    = sb_full_w;

  cq_ring #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc_w), .alloc_pc(disp_pc), .alloc_store(disp_store),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .pop_cnt(pop_w), .flush(flush_w),
    .tail_ptr(disp_tag), .occ(occ_w),
    .h0_f(h0_w), .h0_pc(h0_pc_w), .h1_f(h1_w), .h1_pc(h1_pc_w)
  );

  cq_retire #(.PC_W(PC_W)) u_ret (
    .h0_f(h0_w), .h0_pc(h0_pc_w), .h1_f(h1_w), .h1_pc(h1_pc_w),
    .pend(pend_w), .gate_done(gate_w), .sb_full(sb_full_w), .mem_gnt(mem_gnt),
    .ret_valid(ret_valid), .pop_cnt(pop_w), .push(push_w), .push_pc(push_pc_w)
  );

  cq_stbuf #(.PC_W(PC_W)) u_sb (
    .clk(clk), .rst_n(rst_n), .push(push_w), .push_pc(push_pc_w),
    .mem_gnt(mem_gnt), .full(sb_full_w), .mem_pc(mem_pc)
  );

  cq_irq_gate #(.PC_W(PC_W), .MSR_W(MSR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .msr_wr(msr_wr), .msr_wdata(msr_wdata),
    .h0_f(h0_w), .h0_pc(h0_pc_w), .q_empty(occ_w == '0),
    .sb_full(sb_full_w), .head_ret(ret_valid[0]), .fetch_pc(fetch_pc),
    .pend(pend_w), .gate_done(gate_w), .trap_take(trap_take), .irq_take(irq_take),
    .msr(msr), .save_pc(save_pc), .save_msr(save_msr)
  );

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH = 5,
  parameter int PC_W  = 16,
  parameter int MSR_W = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_ready,
  input logic [OCC_W-1:0] occ,
  input logic [1:0]       ret_valid,
  input logic             pend,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic [PC_W-1:0]  mem_pc,
  input logic             trap_take,
  input logic             irq_take,
  input logic [MSR_W-1:0] msr
);

  p_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[1] |-> ret_valid[0]);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !disp_ready);

  p_hold_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_pc)));

  p_single_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !ret_valid[1]);

  p_sync_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> !irq_take);

  p_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !mem_req);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take || trap_take) |=> (occ == '0 && !msr[0]));

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !msr[0] |-> !irq_take);

endmodule

bind retire_queue cq_checker #(.DEPTH(DEPTH), .PC_W(PC_W), .MSR_W(MSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_ready(disp_ready), .occ(occ_w),
  .ret_valid(ret_valid), .pend(pend_w), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_pc(mem_pc), .trap_take(trap_take), .irq_take(irq_take), .msr(msr)
);

// File: tb/retire_queue_test.sv
module retire_queue_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0, disp_store = 1'b0;
  logic [15:0] disp_pc = '0, fetch_pc = '0;
  logic        disp_ready;
  logic [2:0]  disp_tag, fin_tag = '0;
  logic        fin_valid = 1'b0, fin_exc = 1'b0;
  logic [1:0]  ret_valid;
  logic        mem_req, mem_gnt = 1'b0, irq_req = 1'b0;
  logic [15:0] mem_pc, save_pc;
  logic        msr_wr = 1'b0;
  logic [3:0]  msr_wdata = '0, msr, save_msr;
  logic        trap_take, irq_take;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  retire_queue uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pc(disp_pc),
    .disp_store(disp_store), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .ret_valid(ret_valid), .mem_req(mem_req), .mem_pc(mem_pc), .mem_gnt(mem_gnt),
    .irq_req(irq_req), .fetch_pc(fetch_pc), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
    .msr(msr), .trap_take(trap_take), .irq_take(irq_take),
    .save_pc(save_pc), .save_msr(save_msr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; disp_valid = 0; fin_valid = 0; fin_exc = 0; mem_gnt = 0;
    irq_req = 0; msr_wr = 0; disp_store = 0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic disp(input logic [15:0] pc, input logic st, input int tag);
    disp_valid = 1; disp_pc = pc; disp_store = st;
    #2;
    chk("R2", "ready at dispatch", 32'(disp_ready), 1);
    chk("R2", "allocated tag", 32'(disp_tag), 32'(tag));
    tick();
    disp_valid = 0; disp_store = 0;
  endtask

  task automatic fin(input int tag, input logic exc);
    fin_valid = 1; fin_tag = 3'(tag); fin_exc = exc;
    tick();
    fin_valid = 0; fin_exc = 0;
  endtask

  task automatic wmsr(input logic [3:0] v);
    msr_wr = 1; msr_wdata = v;
    tick();
    msr_wr = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #2;
    chk("R2", "ready after reset", 32'(disp_ready), 1);
    chk("R2", "first tag", 32'(disp_tag), 0);
    chk("R1", "no retire after reset", 32'(ret_valid), 0);
    chk("R3", "no store request", 32'(mem_req), 0);
    chk("R10", "machine state reset", 32'(msr), 0);
    wmsr(4'hB);
    #2;
    chk("R10", "machine state written", 32'(msr), 32'hB);
  endtask

  task automatic t_in_order();
    do_reset();
    disp(16'h100, 0, 0); disp(16'h104, 0, 1); disp(16'h108, 0, 2);
    fin(2, 0); #2; chk("R1", "youngest finished alone", 32'(ret_valid), 0);
    fin(1, 0); #2; chk("R1", "head still unfinished", 32'(ret_valid), 0);
    fin(0, 0); #2; chk("R1", "two oldest retire", 32'(ret_valid), 3);
    tick();   #2; chk("R1", "third retires next", 32'(ret_valid), 1);
    tick();   #2; chk("R1", "nothing left", 32'(ret_valid), 0);
  endtask

  task automatic t_full_wrap();
    do_reset();
    for (int i = 0; i < 5; i++) disp(16'h180 + 16'(4 * i), 0, i);
    disp_valid = 1; #2;
    chk("R2", "refused when full", 32'(disp_ready), 0);
    tick(); disp_valid = 0;
    for (int i = 0; i < 5; i++) fin(i, 0);
    tick(); tick();
    disp(16'h1A0, 0, 0);
  endtask

  task automatic t_store();
    do_reset();
    disp(16'h200, 1, 0); disp(16'h204, 1, 1); disp(16'h208, 0, 2);
    #2; chk("R3", "no request before retirement", 32'(mem_req), 0);
    fin(0, 0); #2;
    chk("R3", "first store retires", 32'(ret_valid), 1);
    chk("R3", "request not yet raised", 32'(mem_req), 0);
    tick(); #2;
    chk("R3", "request after retire", 32'(mem_req), 1);
    chk("R3", "request address", 32'(mem_pc), 32'h200);
    fin(1, 0); #2; chk("R4", "store stalls on full slot", 32'(ret_valid), 0);
    fin(2, 0); #2; chk("R4", "younger stalls too", 32'(ret_valid), 0);
    chk("R4", "address held", 32'(mem_pc), 32'h200);
    mem_gnt = 1; #1;
    chk("R4", "grant frees slot same cycle", 32'(ret_valid), 3);
    tick(); mem_gnt = 0; #2;
    chk("R4", "second store waiting", 32'(mem_pc), 32'h204);
    mem_gnt = 1; tick(); mem_gnt = 0; #2;
    chk("R4", "slot empty after grant", 32'(mem_req), 0);
  endtask

  task automatic t_irq_gate();
    do_reset();
    wmsr(4'hB);
    disp(16'h300, 0, 0); disp(16'h304, 0, 1); disp(16'h308, 0, 2);
    fin(2, 0); fin(1, 0);
    fin_valid = 1; fin_tag = 3'd0; irq_req = 1; #2;
    chk("R2", "refused while pending", 32'(disp_ready), 0);
    chk("R7", "head unresolved, no take", 32'(irq_take), 0);
    tick(); fin_valid = 0; #2;
    chk("R5", "only head retires", 32'(ret_valid), 1);
    chk("R7", "no take before head resolves", 32'(irq_take), 0);
    tick(); #2;
    chk("R5", "younger entries held", 32'(ret_valid), 0);
    chk("R7", "interrupt taken", 32'(irq_take), 1);
    tick(); #2;
    chk("R7", "resume address", 32'(save_pc), 32'h304);
    chk("R8", "saved machine state", 32'(save_msr), 32'hB);
    chk("R8", "enable cleared", 32'(msr), 32'hA);
    chk("R8", "tag restarts at 0", 32'(disp_tag), 0);
    chk("R8", "ready after take", 32'(disp_ready), 1);
    fin(1, 0); #2;
    chk("R8", "stale finish retires nothing", 32'(ret_valid), 0);
    irq_req = 0;
  endtask

  task automatic t_irq_store();
    do_reset();
    wmsr(4'h1);
    disp(16'h400, 1, 0); disp(16'h404, 0, 1);
    fin(1, 0);
    fin_valid = 1; fin_tag = 3'd0; irq_req = 1;
    tick(); fin_valid = 0; #2;
    chk("R5", "head store retires", 32'(ret_valid), 1);
    tick(); #2;
    chk("R7", "wait for store slot", 32'(irq_take), 0);
    chk("R3", "store requested", 32'(mem_req), 1);
    tick(); #2;
    chk("R7", "still waiting", 32'(irq_take), 0);
    mem_gnt = 1; #1;
    chk("R7", "grant cycle not yet drained", 32'(irq_take), 0);
    tick(); mem_gnt = 0; #2;
    chk("R7", "take after drain", 32'(irq_take), 1);
    tick(); #2;
    chk("R7", "resume after store", 32'(save_pc), 32'h404);
    irq_req = 0;
  endtask

  task automatic t_trap_first();
    do_reset();
    wmsr(4'h1);
    disp(16'h500, 0, 0); disp(16'h504, 0, 1);
    fin_valid = 1; fin_tag = 3'd0; fin_exc = 1; irq_req = 1;
    tick(); fin_valid = 0; fin_exc = 0; #2;
    chk("R6", "head exception taken", 32'(trap_take), 1);
    chk("R6", "interrupt deferred", 32'(irq_take), 0);
    chk("R6", "nothing retires", 32'(ret_valid), 0);
    tick(); #2;
    chk("R6", "fault address saved", 32'(save_pc), 32'h500);
    chk("R8", "enable cleared by trap", 32'(msr), 0);
    chk("R8", "queue emptied", 32'(disp_tag), 0);
    irq_req = 0;
  endtask

  task automatic t_masked();
    do_reset();
    irq_req = 1;
    disp(16'h600, 0, 0); disp(16'h604, 0, 1);
    fin(1, 0); fin(0, 0); #2;
    chk("R9", "dual retire with enable clear", 32'(ret_valid), 3);
    chk("R9", "no interrupt", 32'(irq_take), 0);
    irq_req = 0;
  endtask

  task automatic t_irq_empty();
    do_reset();
    fetch_pc = 16'h7F0;
    wmsr(4'h1);
    irq_req = 1; msr_wr = 1; msr_wdata = 4'hF; #2;
    chk("R7", "take with empty queue", 32'(irq_take), 1);
    tick(); msr_wr = 0; #2;
    chk("R7", "fetch address saved", 32'(save_pc), 32'h7F0);
    chk("R10", "take overrides write", 32'(msr), 0);
    chk("R8", "state before take", 32'(save_msr), 1);
    irq_req = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    t_reset_state();
    t_in_order();
    t_full_wrap();
    t_store();
    t_irq_gate();
    t_irq_store();
    t_trap_first();
    t_masked();
    t_irq_empty();
    done = 1'b1;
    report();
  end

endmodule